// File: doc/BRIEF.md
# Staged Shifter With Fill Bit

This block is a purely combinational shift unit for a 32-bit datapath. It has one left-shifting core. The core moves its operand toward the most significant end by a 5-bit unsigned amount and fills every vacated low position with a fill bit. The core is five conditional stages that shift by 16, 8, 4, 2 and 1. Bit 4 of the amount enables the 16-position stage and bit 0 enables the single-position stage. Each stage is a fixed rewiring of the bus followed by a two-way select.

A wrapper around the core provides three shift modes, chosen by a 2-bit mode input. Right shifts do not use a second shifter. The wrapper mirrors the operand's bit order on the way into the left core and mirrors the core's result on the way out. The fill bit is 0 for both logical shifts. For the arithmetic right shift it is the operand's top bit, so the sign spreads into the vacated upper positions.

Top module: `shift_unit`

## Requirements
- R1: With mode 2'b00 the result is operand_b shifted toward bit 31 by shamt positions, and the low shamt bits are 0.
- R2: When shamt is 0 the result equals operand_b in every mode.
- R3: Mode 2'b01 gives the same result as mode 2'b00 for every operand and amount.
- R4: With mode 2'b10 the result is operand_b shifted toward bit 0 by shamt positions, and the high shamt bits are 0.
- R5: With mode 2'b11 the result is operand_b shifted toward bit 0 by shamt positions, and the high shamt bits all equal operand_b[31].
- R6: At shamt 31, mode 2'b00 gives operand_b[0] at bit 31 and zeros elsewhere. Mode 2'b10 gives operand_b[31] at bit 0 and zeros elsewhere. Mode 2'b11 gives 32 copies of operand_b[31].
- R7: The result depends only on the present inputs. When inputs change, the result follows in the same cycle, with no dependence on earlier inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_b | input | 32 | Value to be shifted |
| shamt | input | 5 | Unsigned shift amount, 0 to 31 |
| mode | input | 2 | 00/01 left logical, 10 right logical, 11 right arithmetic |
| result | output | 32 | Shifted value |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between any input and the output. The bench applies new inputs one time unit after a rising clock edge. It samples the result at the following falling edge, once the combinational path has settled and before the next stimulus. Back-to-back vectors with differing amounts and modes show that nothing carries over from one vector to the next.

// File: rtl/shift_pkg.sv
// Package: shared types for the shift unit.
// Assumes: mode is a 2-bit code; the low bit only matters when the high bit is set.
package shift_pkg;
    typedef enum logic [1:0] {
        MODE_LEFT     = 2'b00,
        MODE_LEFT_ALT = 2'b01,
        MODE_RIGHT_LG = 2'b10,
        MODE_RIGHT_AR = 2'b11
    } shift_mode_e;
endpackage

// File: rtl/shift_stage.sv
// Module: one conditional stage of the left core.
// It shifts by a fixed distance DIST, or passes the bus straight through.
// The shifted path is pure rewiring; the only logic is a two-way select.
// Assumes: 0 < DIST < WIDTH.
module shift_stage #(
    parameter int WIDTH = 32,
    parameter int DIST  = 1
) (
    input  logic [WIDTH-1:0] din,
    input  logic             en,
    input  logic             fill,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] moved;

    // Rewire the bus up by DIST positions and put fill into the freed positions.
    always_comb moved = {din[WIDTH-1-DIST:0], {DIST{fill}}};

    // Choose the shifted or the untouched bus.
    always_comb dout = en ? moved : din;
endmodule

// File: rtl/bit_mirror.sv
// Module: reverses the bit order of a bus; bit i goes to bit WIDTH-1-i.
// It uses wires only.
module bit_mirror #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_swap
            assign dout[i] = din[WIDTH-1-i];
        end
    endgenerate
endmodule

// File: rtl/left_core.sv
// Module: staged left shifter with an external fill bit.
// It is a cascade of SHAMT_W stages with distances 2^(SHAMT_W-1) down to 1.
// Amount bit k enables the stage of distance 2^k.
// Assumes: WIDTH is a power of two and SHAMT_W = log2(WIDTH).
module left_core #(
    parameter int WIDTH   = 32,
    parameter int SHAMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0]   din,
    input  logic [SHAMT_W-1:0] amt,
    input  logic               fill,
    output logic [WIDTH-1:0]   dout
);
    logic [WIDTH-1:0] level [0:SHAMT_W];

    // The first level is the raw operand.
    always_comb level[0] = din;

    genvar s;
    generate
        for (s = 0; s < SHAMT_W; s++) begin : g_stage
            localparam int BITSEL = SHAMT_W - 1 - s;
            shift_stage #(.WIDTH(WIDTH), .DIST(1 << BITSEL)) u_stage (
                .din  (level[s]),
                .en   (amt[BITSEL]),
                .fill (fill),
                .dout (level[s+1])
            );
        end
    endgenerate

    // The last level is the core result.
    always_comb dout = level[SHAMT_W];

    // Check that every vacated low bit carries the fill value.
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            if (i < int'(amt)) begin
                AST_CORE_FILL: assert (dout[i] == fill); // R1
            end
        end
    end
endmodule

// File: rtl/shift_unit.sv
// Module: three-mode shift unit built on a single left core.
// Right shifts mirror the operand into the core and mirror the result back out.
// The fill bit is 0 for logical shifts and operand_b[WIDTH-1] for the arithmetic shift.
// Assumes: purely combinational; no clock and no reset.
module shift_unit #(
    parameter int WIDTH   = 32,
    parameter int SHAMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0]   operand_b,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic [1:0]         mode,
    output logic [WIDTH-1:0]   result
);
    import shift_pkg::*;

    shift_mode_e      mode_e;
    logic             go_right;
    logic             fill_bit;
    logic [WIDTH-1:0] mirrored_in;
    logic [WIDTH-1:0] core_in;
    logic [WIDTH-1:0] core_out;
    logic [WIDTH-1:0] mirrored_out;

    // Decode the mode: direction select and fill source.
    always_comb begin
        mode_e   = shift_mode_e'(mode);
        go_right = (mode_e == MODE_RIGHT_LG) || (mode_e == MODE_RIGHT_AR);
        fill_bit = (mode_e == MODE_RIGHT_AR) ? operand_b[WIDTH-1] : 1'b0;
    end

    bit_mirror #(.WIDTH(WIDTH)) u_mirror_in (
        .din  (operand_b),
        .dout (mirrored_in)
    );

    // Feed the core either the plain operand or its mirror.
    always_comb core_in = go_right ? mirrored_in : operand_b;

    left_core #(.WIDTH(WIDTH), .SHAMT_W(SHAMT_W)) u_core (
        .din  (core_in),
        .amt  (shamt),
        .fill (fill_bit),
        .dout (core_out)
    );

    bit_mirror #(.WIDTH(WIDTH)) u_mirror_out (
        .din  (core_out),
        .dout (mirrored_out)
    );

    // Undo the mirror for right shifts.
    always_comb result = go_right ? mirrored_out : core_out;

    // Port-level checks on the vacated positions and the pass-through case.
    always_comb begin
        if (shamt == '0) begin
            AST_ZERO_PASS: assert (result == operand_b); // R2
        end
        for (int i = 0; i < WIDTH; i++) begin
            if (i < int'(shamt) && mode == 2'b00) begin
                AST_LEFT_ZERO: assert (result[i] == 1'b0); // R1
            end
            if (i < int'(shamt) && mode == 2'b10) begin
                AST_RIGHT_ZERO: assert (result[WIDTH-1-i] == 1'b0); // R4
            end
            if (i < int'(shamt) && mode == 2'b11) begin
                AST_SIGN_FILL: assert (result[WIDTH-1-i] == operand_b[WIDTH-1]); // R5
            end
        end
    end
endmodule

// File: tb/tb_shift_unit.sv
module tb_shift_unit;
    logic        clk = 1'b0;
    logic [31:0] operand_b = '0;
    logic [4:0]  shamt = '0;
    logic [1:0]  mode = '0;
    logic [31:0] result;
    int          checks = 0;
    int          failures = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    shift_unit dut (
        .operand_b (operand_b),
        .shamt     (shamt),
        .mode      (mode),
        .result    (result)
    );

    // Bit-by-bit reference model taken from the requirements.
    function automatic logic [31:0] ref_shift(logic [31:0] b, int sa, logic [1:0] m);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) begin
            if (!m[1]) r[i] = (i - sa >= 0) ? b[i-sa] : 1'b0;
            else       r[i] = (i + sa < 32) ? b[i+sa] : (m[0] ? b[31] : 1'b0);
        end
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s b=%h sa=%0d mode=%b got=%h exp=%h", tag, operand_b, shamt, mode, got, exp);
        end
    endtask

    // Apply one vector after a rising edge and check it at the falling edge.
    task automatic apply(string tag, logic [31:0] b, int sa, logic [1:0] m, logic [31:0] exp);
        @(posedge clk);
        #1;
        operand_b = b;
        shamt = 5'(sa);
        mode = m;
        @(negedge clk);
        check(tag, result, exp);
    endtask

    task automatic vec(string tag, logic [31:0] b, int sa, logic [1:0] m);
        apply(tag, b, sa, m, ref_shift(b, sa, m));
    endtask

    initial begin
        logic [31:0] rb;
        logic [31:0] r0;
        int sa;
        @(negedge clk);
        check("R7 initial zero", result, 32'h0);
        apply("R1 left by 4", 32'h1234_5678, 4, 2'b00, 32'h2345_6780);
        apply("R4 right logical by 8", 32'hF000_00F0, 8, 2'b10, 32'h00F0_0000);
        apply("R5 right arith by 8", 32'hF000_00F0, 8, 2'b11, 32'hFFF0_0000);
        apply("R5 right arith positive", 32'h7000_0000, 4, 2'b11, 32'h0700_0000);
        apply("R2 zero amount left", 32'hDEAD_BEEF, 0, 2'b00, 32'hDEAD_BEEF);
        apply("R2 zero amount right", 32'hDEAD_BEEF, 0, 2'b10, 32'hDEAD_BEEF);
        apply("R2 zero amount arith", 32'hDEAD_BEEF, 0, 2'b11, 32'hDEAD_BEEF);
        apply("R3 mode 01 left", 32'h0000_00FF, 12, 2'b01, 32'h000F_F000);
        apply("R6 left by 31", 32'hFFFF_FFFF, 31, 2'b00, 32'h8000_0000);
        apply("R6 right by 31", 32'h8000_0001, 31, 2'b10, 32'h0000_0001);
        apply("R6 arith by 31 neg", 32'h8000_0000, 31, 2'b11, 32'hFFFF_FFFF);
        apply("R6 arith by 31 pos", 32'h7FFF_FFFF, 31, 2'b11, 32'h0000_0000);
        apply("R1 left by 16", 32'h0000_ABCD, 16, 2'b00, 32'hABCD_0000);
        apply("R7 back to back", 32'h0000_0001, 1, 2'b10, 32'h0000_0000);
        for (int k = 0; k < 32; k++) begin
            vec("R1 sweep", 32'hA5C3_9617, k, 2'b00);
            vec("R4 sweep", 32'hA5C3_9617, k, 2'b10);
            vec("R5 sweep", 32'hA5C3_9617, k, 2'b11);
        end
        r0 = $urandom(32'd4321);
        for (int n = 0; n < 400; n++) begin
            rb = $urandom;
            sa = int'($urandom_range(31, 0));
            vec("R1 random", rb, sa, 2'b00);
            r0 = result;
            vec("R3 random", rb, sa, 2'b01);
            check("R3 alias match", result, r0);
            vec("R4 random", rb, sa, 2'b10);
            vec("R5 random", rb, sa, 2'b11);
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL R7 watchdog expired got=hung exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule